// File: doc/BRIEF.md
# Lockable Protection Register Bank

This block stores the per-entry settings of a memory protection unit: one configuration byte and one address register for each of `NUM_ENTRIES` entries. Configuration bytes are grouped four to a 32-bit register. A single write port, selected between the configuration and address spaces, updates the bank. A read port returns the stored contents one cycle later.

Each configuration byte carries three permission bits (bits 2:0), a two-bit address-matching mode (bits 4:3: 0 off, 1 top-of-range, 2 naturally aligned four-byte, 3 naturally aligned power of two), two spare bits (6:5) and a lock bit (bit 7). Once an entry is locked, the bank refuses writes to that entry's configuration byte and address register. When the locked entry uses top-of-range mode, the bank also refuses writes to the address register just below it. Only a reset releases the locks.

The bank drives the decoded per-entry fields straight from its storage for a neighbouring access checker. It also drives two registered summaries: a flag that is high when any entry is locked, and a count of the entries whose mode is not off.

Top module: `lockreg_bank`

## Requirements
- R1: A configuration write (`wr_to_addr`=0, `wr_idx`=j) stores byte b of `wr_data` (bits 8b+7:8b) into entry 4j+b. An address write (`wr_to_addr`=1, `wr_idx`=i) stores `wr_data[ADDR_W-1:0]` into entry i. A read presents the selected register on `rd_data` one clock after the request, with byte b of a configuration read holding entry 4j+b.
- R2: A configuration byte whose lock bit (bit 7) is set keeps its old value on a configuration write. The other bytes of the same register take the new data.
- R3: A write to the address register of a locked entry is ignored.
- R4: A write to address register i is ignored when entry i+1 is locked and its mode field (bits 4:3) equals 1 (top-of-range). It is accepted when entry i+1 is locked in any other mode.
- R5: The address register of the last entry is protected only by that entry's own lock. A locked top-of-range entry 0 does not protect it.
- R6: A reset clears bit 7 and bits 4:3 of every configuration byte. It keeps bits 2:0 and 6:5 and all address registers, after which every register is writable again.
- R7: `any_locked` is high one clock after at least one lock bit is set, and low one clock after none is. It is low out of reset.
- R8: `active_count` equals, one clock later, the number of entries whose mode field is not 0, and is 0 out of reset.
- R9: `entry_lock`, `entry_mode`, `entry_perm` and `entry_addr` present the stored fields of each entry directly, with no added delay. Entry e occupies bit e, bits 2e+1:2e, bits 3e+2:3e and bits ADDR_W*e+ADDR_W-1:ADDR_W*e respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, releases locks |
| wr_en | input | 1 | Write strobe |
| wr_to_addr | input | 1 | 1 selects address registers, 0 selects packed configuration registers |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | 32 | Write data |
| rd_from_addr | input | 1 | 1 reads an address register, 0 a configuration register |
| rd_idx | input | IDX_W | Register index of the read |
| rd_data | output | 32 | Read data, one clock after the request |
| any_locked | output | 1 | Registered OR of all lock bits |
| active_count | output | CNT_W | Registered count of entries with mode not off |
| entry_lock | output | NUM_ENTRIES | Lock bit per entry |
| entry_mode | output | 2*NUM_ENTRIES | Mode field per entry |
| entry_perm | output | 3*NUM_ENTRIES | Permission bits per entry |
| entry_addr | output | ADDR_W*NUM_ENTRIES | Address register per entry |

## Verification
The bench rewrites a packed register that mixes locked and unlocked bytes. A bank that protected whole registers would freeze the unlocked neighbours, and one that ignored locks would overwrite the locked byte. It then locks entries in top-of-range and in four-byte mode and writes the address below each. A design that ignored the neighbour rule, or applied it to every mode, would accept the first of these writes or refuse the second. It locks entry 0 in top-of-range mode and writes the last address register, which a design with a wrap-around neighbour index would wrongly refuse. Finally it resets the bank and reads everything back, which shows whether the permission bits and addresses were wrongly wiped or the locks wrongly kept.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
  localparam int CFG_BYTES  = 4;
  localparam int LOCK_POS   = 7;
  localparam int MODE_LO    = 3;
  localparam int MODE_HI    = 4;
  localparam int PERM_HI    = 2;
  localparam logic [7:0] RST_KEEP_MASK = 8'h67;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;
endpackage

// File: rtl/lockreg_cfg_slot.sv
module lockreg_cfg_slot
  import lockreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_q & RST_KEEP_MASK;
    end else if (we && !cfg_q[LOCK_POS]) begin
      cfg_q <= wdata;
    end
  end
endmodule

// File: rtl/lockreg_addr_slot.sv
module lockreg_addr_slot
  import lockreg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit HAS_NEXT = 1'b1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              own_lock,
  input  logic              next_lock,
  input  logic [1:0]        next_mode,
  output logic [ADDR_W-1:0] addr_q
);
  logic guarded;

  generate
    if (HAS_NEXT) begin : g_chain
      assign guarded = own_lock | (next_lock & (next_mode == AM_TOR));
    end else begin : g_tail
      logic unused_next;
      assign unused_next = next_lock ^ (^next_mode);
      assign guarded = own_lock;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we && !guarded) begin
      addr_q <= wdata;
    end
  end
endmodule

// File: rtl/lockreg_summary.sv
module lockreg_summary
  import lockreg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_ENTRIES-1:0]   lock_vec,
  input  logic [2*NUM_ENTRIES-1:0] mode_vec,
  output logic                     any_locked,
  output logic [CNT_W-1:0]         active_count
);
  logic [CNT_W-1:0] count_next;

  always_comb begin
    count_next = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (mode_vec[2*e +: 2] != AM_OFF) begin
        count_next = count_next + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_locked   <= 1'b0;
      active_count <= '0;
    end else begin
      any_locked   <= |lock_vec;
      active_count <= count_next;
    end
  end
endmodule

// File: rtl/lockreg_bank.sv
module lockreg_bank
  import lockreg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  localparam int REG_W   = 32,
  localparam int NUM_CFG = NUM_ENTRIES / CFG_BYTES,
  localparam int IDX_W   = $clog2(NUM_ENTRIES),
  localparam int CNT_W   = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          wr_to_addr,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [REG_W-1:0]              wr_data,
  input  logic                          rd_from_addr,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [REG_W-1:0]              rd_data,
  output logic                          any_locked,
  output logic [CNT_W-1:0]              active_count,
  output logic [NUM_ENTRIES-1:0]        entry_lock,
  output logic [2*NUM_ENTRIES-1:0]      entry_mode,
  output logic [3*NUM_ENTRIES-1:0]      entry_perm,
  output logic [ADDR_W*NUM_ENTRIES-1:0] entry_addr
);
  logic [7:0]        cfg_q  [NUM_ENTRIES];
  logic [ADDR_W-1:0] addr_q [NUM_ENTRIES];
  logic [REG_W-1:0]  rd_next;

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      localparam int REG_SEL  = e / CFG_BYTES;
      localparam int BYTE_SEL = e % CFG_BYTES;
      localparam int NEXT_E   = (e + 1 < NUM_ENTRIES) ? e + 1 : e;
      logic cfg_we;
      logic addr_we;

      assign cfg_we  = wr_en && !wr_to_addr && (wr_idx == IDX_W'(REG_SEL));
      assign addr_we = wr_en &&  wr_to_addr && (wr_idx == IDX_W'(e));

      lockreg_cfg_slot u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (wr_data[8*BYTE_SEL +: 8]),
        .cfg_q (cfg_q[e])
      );

      lockreg_addr_slot #(
        .ADDR_W   (ADDR_W),
        .HAS_NEXT (e + 1 < NUM_ENTRIES)
      ) u_addr (
        .clk       (clk),
        .we        (addr_we),
        .wdata     (wr_data[ADDR_W-1:0]),
        .own_lock  (cfg_q[e][LOCK_POS]),
        .next_lock (cfg_q[NEXT_E][LOCK_POS]),
        .next_mode (cfg_q[NEXT_E][MODE_HI:MODE_LO]),
        .addr_q    (addr_q[e])
      );

      assign entry_lock[e]             = cfg_q[e][LOCK_POS];
      assign entry_mode[2*e +: 2]      = cfg_q[e][MODE_HI:MODE_LO];
      assign entry_perm[3*e +: 3]      = cfg_q[e][PERM_HI:0];
      assign entry_addr[ADDR_W*e +: ADDR_W] = addr_q[e];
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (rd_from_addr) begin
        if (rd_idx == IDX_W'(e)) begin
          rd_next = REG_W'(addr_q[e]);
        end
      end else if (rd_idx == IDX_W'(e / CFG_BYTES)) begin
        rd_next[8*(e % CFG_BYTES) +: 8] = cfg_q[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end

  lockreg_summary #(
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_summary (
    .clk          (clk),
    .rst          (rst),
    .lock_vec     (entry_lock),
    .mode_vec     (entry_mode),
    .any_locked   (any_locked),
    .active_count (active_count)
  );

  if (NUM_CFG * CFG_BYTES != NUM_ENTRIES) begin : g_bad_cfg
    initial $error("NUM_ENTRIES must be a multiple of four");
  end
endmodule

// File: rtl/lockreg_bank_chk.sv
module lockreg_bank_chk
  import lockreg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          any_locked,
  input logic [CNT_W-1:0]              active_count,
  input logic [NUM_ENTRIES-1:0]        entry_lock,
  input logic [2*NUM_ENTRIES-1:0]      entry_mode,
  input logic [ADDR_W*NUM_ENTRIES-1:0] entry_addr
);
  logic [NUM_ENTRIES-1:0] live_vec;

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      live_vec[e] = (entry_mode[2*e +: 2] != AM_OFF);
    end
  end

  // R7
  any_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (any_locked == (|$past(entry_lock))));

  // R8
  active_count_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (active_count == CNT_W'($countones($past(live_vec)))));

  // R6
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (entry_lock == '0 && entry_mode == '0));

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      // R2
      locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        entry_lock[e] |=> (entry_lock[e] && $stable(entry_mode[2*e +: 2])));

      // R3
      locked_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        entry_lock[e] |=> $stable(entry_addr[ADDR_W*e +: ADDR_W]));

      if (e + 1 < NUM_ENTRIES) begin : g_prev
        // R4
        tor_prev_hold_chk: assert property (@(posedge clk) disable iff (rst)
          (entry_lock[e+1] && entry_mode[2*(e+1) +: 2] == AM_TOR)
          |=> $stable(entry_addr[ADDR_W*e +: ADDR_W]));
      end
    end
  endgenerate
endmodule

bind lockreg_bank lockreg_bank_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .any_locked   (any_locked),
  .active_count (active_count),
  .entry_lock   (entry_lock),
  .entry_mode   (entry_mode),
  .entry_addr   (entry_addr)
);

// File: tb/lockreg_bank_bench.sv
module lockreg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int AW     = 32;
  localparam int IDX_W  = $clog2(N);
  localparam int CNT_W  = $clog2(N + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              wr_to_addr = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [31:0]       wr_data = '0;
  logic              rd_from_addr = 1'b0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [31:0]       rd_data;
  logic              any_locked;
  logic [CNT_W-1:0]  active_count;
  logic [N-1:0]      entry_lock;
  logic [2*N-1:0]    entry_mode;
  logic [3*N-1:0]    entry_perm;
  logic [AW*N-1:0]   entry_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockreg_bank #(.NUM_ENTRIES(N), .ADDR_W(AW)) u_lockreg_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_to_addr(wr_to_addr),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_from_addr(rd_from_addr),
    .rd_idx(rd_idx), .rd_data(rd_data), .any_locked(any_locked),
    .active_count(active_count), .entry_lock(entry_lock),
    .entry_mode(entry_mode), .entry_perm(entry_perm), .entry_addr(entry_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic to_addr, input int idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_to_addr = to_addr; wr_idx = IDX_W'(idx); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic from_addr, input int idx, output logic [31:0] data);
    @(negedge clk);
    rd_from_addr = from_addr; rd_idx = IDX_W'(idx);
    @(negedge clk);
    data = rd_data;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R7 any_locked after reset", 32'(any_locked), 32'd0);
    check("R8 active_count after reset", 32'(active_count), 32'd0);
    check("R9 entry_lock after reset", 32'(entry_lock), 32'd0);
    check("R9 entry_mode after reset", 32'(entry_mode), 32'd0);
  endtask

  task automatic t_plain_cfg();
    logic [31:0] v;
    wr(1'b0, 1, 32'h0000_0000);
    wr(1'b0, 0, 32'h1300_1F0B);
    rd(1'b0, 0, v);
    check("R1 cfg0 readback", v, 32'h1300_1F0B);
    check("R9 entry0 mode", 32'(entry_mode[1:0]), 32'd1);
    check("R9 entry0 perm", 32'(entry_perm[2:0]), 32'd3);
    check("R9 entry3 mode", 32'(entry_mode[7:6]), 32'd2);
    check("R8 three active", 32'(active_count), 32'd3);
    check("R7 none locked", 32'(any_locked), 32'd0);
  endtask

  task automatic t_plain_addr();
    logic [31:0] v;
    for (int e = 0; e < N; e++) wr(1'b1, e, 32'h1000_0000 + 32'(e) * 32'h100);
    rd(1'b1, 2, v);
    check("R1 addr2 readback", v, 32'h1000_0200);
    rd(1'b1, 7, v);
    check("R1 addr7 readback", v, 32'h1000_0700);
    check("R9 entry_addr5", entry_addr[AW*5 +: AW], 32'h1000_0500);
  endtask

  task automatic t_byte_lock();
    logic [31:0] v;
    wr(1'b0, 1, 32'h0000_0089);
    settle();
    check("R7 lock raises flag", 32'(any_locked), 32'd1);
    check("R8 four active", 32'(active_count), 32'd4);
    wr(1'b0, 1, 32'h0707_0707);
    rd(1'b0, 1, v);
    check("R2 locked byte kept, others written", v, 32'h0707_0789);
    check("R9 entry_lock", 32'(entry_lock), 32'h10);
  endtask

  task automatic t_addr_lock();
    logic [31:0] v;
    wr(1'b1, 4, 32'hAAAA_0004);
    rd(1'b1, 4, v);
    check("R3 locked addr4 unchanged", v, 32'h1000_0400);
    wr(1'b1, 3, 32'hAAAA_0003);
    rd(1'b1, 3, v);
    check("R4 addr3 under TOR lock unchanged", v, 32'h1000_0300);
    wr(1'b1, 5, 32'hBBBB_0005);
    rd(1'b1, 5, v);
    check("R3 unlocked addr5 written", v, 32'hBBBB_0005);
  endtask

  task automatic t_non_tor_lock();
    logic [31:0] v;
    wr(1'b0, 1, 32'h0090_0707);
    rd(1'b0, 1, v);
    check("R2 cfg1 after NA4 lock", v, 32'h0090_0789);
    wr(1'b1, 5, 32'hCCCC_0005);
    rd(1'b1, 5, v);
    check("R4 addr5 below NA4 lock written", v, 32'hCCCC_0005);
    wr(1'b1, 6, 32'hCCCC_0006);
    rd(1'b1, 6, v);
    check("R3 locked addr6 unchanged", v, 32'h1000_0600);
  endtask

  task automatic t_last_entry();
    logic [31:0] v;
    wr(1'b0, 0, 32'h1300_1F89);
    rd(1'b0, 0, v);
    check("R2 cfg0 entry0 lock", v, 32'h1300_1F89);
    wr(1'b1, 7, 32'hDDDD_0007);
    rd(1'b1, 7, v);
    check("R5 addr7 not guarded by entry0", v, 32'hDDDD_0007);
    wr(1'b0, 1, 32'h8800_0000);
    rd(1'b0, 1, v);
    check("R2 cfg1 entry7 lock", v, 32'h8890_0089);
    wr(1'b1, 7, 32'hEEEE_0007);
    rd(1'b1, 7, v);
    check("R5 addr7 own lock", v, 32'hDDDD_0007);
    check("R8 six active", 32'(active_count), 32'd6);
    check("R9 lock map", 32'(entry_lock), 32'hD1);
  endtask

  task automatic t_reset_release();
    logic [31:0] v;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 flag low after reset", 32'(any_locked), 32'd0);
    rd(1'b0, 0, v);
    check("R6 cfg0 after reset", v, 32'h0300_0701);
    rd(1'b0, 1, v);
    check("R6 cfg1 after reset", v, 32'h0000_0001);
    rd(1'b1, 7, v);
    check("R6 addr7 kept", v, 32'hDDDD_0007);
    check("R8 zero active after reset", 32'(active_count), 32'd0);
    wr(1'b1, 4, 32'h4444_0004);
    rd(1'b1, 4, v);
    check("R6 addr4 writable after reset", v, 32'h4444_0004);
    wr(1'b0, 1, 32'h0000_00F5);
    rd(1'b0, 1, v);
    check("R6 cfg1 writable after reset", v, 32'h0000_00F5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_plain_cfg();
    t_plain_addr();
    t_byte_lock();
    t_addr_lock();
    t_non_tor_lock();
    t_last_entry();
    t_reset_release();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule